// File: doc/BRIEF.md
# Quadrature Edge Decoder with Wrapping Position Counter

This block turns the two phase signals of an incremental encoder into signed position steps and keeps a position count between zero and a programmable maximum. The phases enter without any timing relation to the clock. They are resynchronised, and each sampled value is compared with the one before it to find edges. Two decoding schemes are available. The first is a four-times scheme, which counts on every edge of either phase. The second is a step-and-direction scheme, where edges on phase B are the count clock and the level of phase A chooses up or down.

Counting up from the maximum wraps the count to zero and signals an overflow. Counting down from zero reloads the maximum and signals an underflow. A no-wrap option lets the count run past the maximum while still reporting the overflow. The block also provides the following:
- a direction status bit;
- sticky flags for overflow, underflow, direction reversal and compare match;
- an interrupt request gated per flag;
- one-cycle event pulses for a downstream revolution counter or masking stage.

Top module: `qdec_poscnt`

## Requirements
- R1: After reset the position is 0, the direction bit reads 0 (up), all four flags are 0 and all event pulses are low.
- R2: In four-times mode (`cnt_mode`=0), an edge on B alone counts up when the new B level equals the A level, and down otherwise. A rising B with A high counts up; a falling B with A high counts down.
- R3: In four-times mode, an edge on A alone counts up when the new A level differs from the B level, and down otherwise. A rising A with B low counts up; a rising A with B high counts down.
- R4: When both phases change between the same two samples, no count is made.
- R5: In step-and-direction mode (`cnt_mode`=1), a B edge is active when `edge_sel` bit 0 is set and the edge is rising, or when bit 1 is set and the edge is falling. An active edge counts up when A is high and down when A is low. Edges on A never count.
- R6: Counting up while the position equals `max_pos` with `no_wrap`=0 returns the position to 0, sets flag bit 0 (overflow) and pulses `ev_ovf`.
- R7: Counting down while the position is 0 loads `max_pos`, sets flag bit 1 (underflow) and pulses `ev_unf`.
- R8: With `no_wrap`=1, counting up at `max_pos` sets flag bit 0 and pulses `ev_ovf`, but the position becomes `max_pos`+1.
- R9: `dir_down` holds the direction of the latest count (1 = down). A count whose direction differs from `dir_down` sets flag bit 2 (inversion).
- R10: A count whose resulting position equals `cmp_pos` sets flag bit 3 (match).
- R11: Each flag stays set until its `flag_clr` bit is pulsed. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R12: `irq` is high exactly when some flag bit and the matching `irq_en` bit are both 1.
- R13: A phase change on the pins appears in `pos`, and as a one-cycle `ev_up` or `ev_down` pulse, on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| cnt_mode | input | 1 | 0 = four-times decode, 1 = step-and-direction |
| edge_sel | input | 2 | Active B edges in step mode: bit0 rising, bit1 falling |
| no_wrap | input | 1 | 1 = count past the maximum instead of wrapping |
| max_pos | input | CNT_W | Maximum position / underflow reload value |
| cmp_pos | input | CNT_W | Compare value for the match flag |
| flag_clr | input | 4 | Per-flag clear strobe {match, inversion, underflow, overflow} |
| irq_en | input | 4 | Per-flag interrupt enable, same bit order |
| pos | output | CNT_W | Position count |
| dir_down | output | 1 | Direction of the last count, 1 = down |
| flags | output | 4 | Sticky flags {match, inversion, underflow, overflow} |
| irq | output | 1 | Interrupt request |
| ev_up | output | 1 | One-cycle pulse per up count |
| ev_down | output | 1 | One-cycle pulse per down count |
| ev_ovf | output | 1 | One-cycle overflow pulse |
| ev_unf | output | 1 | One-cycle underflow pulse |

## Verification
The assertions assume two things about the inputs. First, `max_pos`, `no_wrap` and the mode inputs stay steady in any cycle where a count is being applied. Second, the encoder phases are asynchronous levels that the synchronizer settles. The stimulus changes configuration only while the phases are idle and the pipeline has drained. It moves the phases one Gray-code step at a time, and it inserts deliberate simultaneous toggles of both phases to exercise R4. Randomised sections keep `max_pos` small so that wrap and reload happen often, and they issue clear strobes at arbitrary times.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int FLG_OVF   = 0;
  localparam int FLG_UNF   = 1;
  localparam int FLG_INV   = 2;
  localparam int FLG_MATCH = 3;

  typedef enum logic {
    MODE_QUAD = 1'b0,
    MODE_STEP = 1'b1
  } cnt_mode_e;

  typedef struct packed {
    logic cur;
    logic prev;
  } phase_smp_t;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int STAGES = 2,
  parameter int NUM_CH = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             raw_in,
  output qdec_pkg::phase_smp_t [NUM_CH-1:0] smp
);
  localparam int LAST = STAGES - 1;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;
    logic              prev_q;

    always_comb begin
      pipe_d = {pipe_q[STAGES-2:0], raw_in[ch]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= '0;
        prev_q <= 1'b0;
      end else begin
        pipe_q <= pipe_d;
        prev_q <= pipe_q[LAST];
      end
    end

    assign smp[ch].cur  = pipe_q[LAST];
    assign smp[ch].prev = prev_q;
  end
endmodule

// File: rtl/qdec_edge_dec.sv
module qdec_edge_dec
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_smp_t ph_a,
  input  phase_smp_t ph_b,
  input  logic       cnt_mode,
  input  logic [1:0] edge_sel,
  output logic       cnt_up,
  output logic       cnt_dn
);
  logic a_chg, b_chg, b_act;

  always_comb begin
    a_chg  = ph_a.cur ^ ph_a.prev;
    b_chg  = ph_b.cur ^ ph_b.prev;
    b_act  = b_chg && ((ph_b.cur && edge_sel[0]) || (!ph_b.cur && edge_sel[1]));
    cnt_up = 1'b0;
    cnt_dn = 1'b0;
    if (cnt_mode_e'(cnt_mode) == MODE_STEP) begin
      cnt_up = b_act && ph_a.cur;
      cnt_dn = b_act && !ph_a.cur;
    end else if (b_chg && !a_chg) begin
      cnt_up = (ph_b.cur == ph_a.cur);
      cnt_dn = (ph_b.cur != ph_a.cur);
    end else if (a_chg && !b_chg) begin
      cnt_up = (ph_a.cur != ph_b.cur);
      cnt_dn = (ph_a.cur == ph_b.cur);
    end
  end

  AST_UP_DN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up && cnt_dn)); // R2

  AST_BOTH_CHG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_a.cur != ph_a.prev) && (ph_b.cur != ph_b.prev) && !cnt_mode) |-> !(cnt_up || cnt_dn)); // R4

  AST_STEP_A_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && (ph_b.cur == ph_b.prev)) |-> !(cnt_up || cnt_dn)); // R5
endmodule

// File: rtl/qdec_pos_core.sv
module qdec_pos_core
  import qdec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cnt_up,
  input  logic                 cnt_dn,
  input  logic                 no_wrap,
  input  logic [CNT_W-1:0]     max_pos,
  input  logic [CNT_W-1:0]     cmp_pos,
  output logic [CNT_W-1:0]     pos,
  output logic                 dir_down,
  output logic [NUM_FLAGS-1:0] flag_set,
  output logic                 ev_up,
  output logic                 ev_down,
  output logic                 ev_ovf,
  output logic                 ev_unf
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] pos_d;
  logic             dir_d;
  logic             hit_ovf, hit_unf, counting, cnt_en;

  always_comb begin
    pos_d   = pos;
    hit_ovf = 1'b0;
    hit_unf = 1'b0;
    if (cnt_up) begin
      if (pos == max_pos) begin
        hit_ovf = 1'b1;
        pos_d   = no_wrap ? pos + ONE : '0;
      end else begin
        pos_d = pos + ONE;
      end
    end else if (cnt_dn) begin
      if (pos == '0) begin
        hit_unf = 1'b1;
        pos_d   = max_pos;
      end else begin
        pos_d = pos - ONE;
      end
    end
    counting = cnt_up || cnt_dn;
    cnt_en   = counting;
    dir_d    = counting ? cnt_dn : dir_down;
    flag_set            = '0;
    flag_set[FLG_OVF]   = hit_ovf;
    flag_set[FLG_UNF]   = hit_unf;
    flag_set[FLG_INV]   = counting && (cnt_dn != dir_down);
    flag_set[FLG_MATCH] = counting && (pos_d == cmp_pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      dir_down <= 1'b0;
    end else if (cnt_en) begin
      pos      <= pos_d;
      dir_down <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_up   <= 1'b0;
      ev_down <= 1'b0;
      ev_ovf  <= 1'b0;
      ev_unf  <= 1'b0;
    end else begin
      ev_up   <= cnt_up;
      ev_down <= cnt_dn;
      ev_ovf  <= hit_ovf;
      ev_unf  <= hit_unf;
    end
  end

  AST_NO_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up || cnt_dn) |=> $stable(pos)); // R13

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up && (pos == max_pos) && !no_wrap) |=> ((pos == '0) && ev_ovf)); // R6

  AST_OVF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up && (pos == max_pos) && no_wrap) |=> ((pos == CNT_W'($past(pos) + ONE)) && ev_ovf)); // R8

  AST_UNF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dn && (pos == '0)) |=> ((pos == $past(max_pos)) && ev_unf)); // R7

  AST_DIR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dn |=> dir_down); // R9

  AST_EV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_up, ev_down})); // R13
endmodule

// File: rtl/qdec_flags.sv
module qdec_flags
  import qdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] flag_set,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic flg_d;

    always_comb begin
      flg_d = flag_set[i] | (flags[i] & ~flag_clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flg_d;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !flag_clr[i]) |=> flags[i]); // R11

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[i] |=> flags[i]); // R11
  end

  always_comb begin
    irq = |(flags & irq_en);
  end
endmodule

// File: rtl/qdec_poscnt.sv
module qdec_poscnt
  import qdec_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enc_a,
  input  logic                 enc_b,
  input  logic                 cnt_mode,
  input  logic [1:0]           edge_sel,
  input  logic                 no_wrap,
  input  logic [CNT_W-1:0]     max_pos,
  input  logic [CNT_W-1:0]     cmp_pos,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [CNT_W-1:0]     pos,
  output logic                 dir_down,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq,
  output logic                 ev_up,
  output logic                 ev_down,
  output logic                 ev_ovf,
  output logic                 ev_unf
);
  localparam int CH_A = 0;
  localparam int CH_B = 1;

  logic [1:0]                 rst_pipe;
  logic                       rst_int_n;
  phase_smp_t [1:0]           smp;
  logic                       cnt_up, cnt_dn;
  logic [NUM_FLAGS-1:0]       flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  qdec_sync #(.STAGES(SYNC_STGS), .NUM_CH(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .raw_in ({enc_b, enc_a}),
    .smp    (smp)
  );

  qdec_edge_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ph_a     (smp[CH_A]),
    .ph_b     (smp[CH_B]),
    .cnt_mode (cnt_mode),
    .edge_sel (edge_sel),
    .cnt_up   (cnt_up),
    .cnt_dn   (cnt_dn)
  );

  qdec_pos_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cnt_up   (cnt_up),
    .cnt_dn   (cnt_dn),
    .no_wrap  (no_wrap),
    .max_pos  (max_pos),
    .cmp_pos  (cmp_pos),
    .pos      (pos),
    .dir_down (dir_down),
    .flag_set (flag_set),
    .ev_up    (ev_up),
    .ev_down  (ev_down),
    .ev_ovf   (ev_ovf),
    .ev_unf   (ev_unf)
  );

  qdec_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .flag_set (flag_set),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .flags    (flags),
    .irq      (irq)
  );

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_en == '0) |-> !irq); // R12

  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rst_int_n) |-> ((pos == '0) && (flags == '0) && !dir_down)); // R1
endmodule

// File: tb/qdec_poscnt_tb.sv
module qdec_poscnt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enc_a, enc_b, cnt_mode, no_wrap;
  logic [1:0]    edge_sel;
  logic [W-1:0]  max_pos, cmp_pos;
  logic [3:0]    flag_clr, irq_en;
  logic [W-1:0]  pos;
  logic          dir_down, irq, ev_up, ev_down, ev_ovf, ev_unf;
  logic [3:0]    flags;

  int n_checks = 0;
  int n_errors = 0;

  // behavioural reference state
  logic [2:0]   hist_a[$];
  logic [2:0]   hist_b[$];
  logic [W-1:0] m_pos;
  logic         m_dir;
  logic [3:0]   m_flags;
  logic         m_up, m_dn, m_ovf, m_unf;
  int           ph;
  logic [1:0]   gray [4] = '{2'b00, 2'b01, 2'b11, 2'b10}; // {b,a}

  always #(CLK_PERIOD/2) clk = ~clk;

  qdec_poscnt #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .cnt_mode(cnt_mode), .edge_sel(edge_sel), .no_wrap(no_wrap),
    .max_pos(max_pos), .cmp_pos(cmp_pos), .flag_clr(flag_clr), .irq_en(irq_en),
    .pos(pos), .dir_down(dir_down), .flags(flags), .irq(irq),
    .ev_up(ev_up), .ev_down(ev_down), .ev_ovf(ev_ovf), .ev_unf(ev_unf)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock of the reference: history index 0 = first sync stage, 1 = settled, 2 = previous
  task automatic model_step(input logic a, input logic b, input logic [3:0] clr);
    logic ac, ap, bc, bp, up, dn, act;
    logic [3:0] setv;
    ac = hist_a[0][1]; ap = hist_a[0][2];
    bc = hist_b[0][1]; bp = hist_b[0][2];
    up = 0; dn = 0;
    if (cnt_mode) begin
      act = (bc != bp) && ((bc && edge_sel[0]) || (!bc && edge_sel[1]));
      up = act && ac; dn = act && !ac;
    end else if ((bc != bp) && (ac == ap)) begin
      if (bc) begin up = ac; dn = !ac; end else begin up = !ac; dn = ac; end
    end else if ((ac != ap) && (bc == bp)) begin
      if (ac) begin up = !bc; dn = bc; end else begin up = bc; dn = !bc; end
    end
    setv = '0; m_ovf = 0; m_unf = 0;
    if (up || dn) begin
      if (dn != m_dir) setv[2] = 1;
      m_dir = dn;
      if (up) begin
        if (m_pos == max_pos) begin
          m_ovf = 1; setv[0] = 1;
          m_pos = no_wrap ? m_pos + 1 : 0;
        end else m_pos = m_pos + 1;
      end else begin
        if (m_pos == 0) begin
          m_unf = 1; setv[1] = 1; m_pos = max_pos;
        end else m_pos = m_pos - 1;
      end
      if (m_pos == cmp_pos) setv[3] = 1;
    end
    m_up = up; m_dn = dn;
    m_flags = setv | (m_flags & ~clr);
    hist_a[0] = {hist_a[0][1], hist_a[0][0], a};
    hist_b[0] = {hist_b[0][1], hist_b[0][0], b};
  endtask

  task automatic compare_all();
    n_checks++;
    if (pos !== m_pos || dir_down !== m_dir || flags !== m_flags ||
        irq !== (|(m_flags & irq_en)) || ev_up !== m_up || ev_down !== m_dn ||
        ev_ovf !== m_ovf || ev_unf !== m_unf) begin
      n_errors++;
      $display("FAIL R13 cycle compare (R2 R3 R6 R7 R9 R11 R12): pos=%0d/%0d dir=%0b/%0b flags=%b/%b irq=%0b ev=%b/%b",
               pos, m_pos, dir_down, m_dir, flags, m_flags, irq,
               {ev_up, ev_down, ev_ovf, ev_unf}, {m_up, m_dn, m_ovf, m_unf});
    end
  endtask

  task automatic tick(input logic a, input logic b, input logic [3:0] clr);
    enc_a = a; enc_b = b; flag_clr = clr;
    model_step(a, b, clr);
    @(posedge clk);
    @(negedge clk);
    compare_all();
    flag_clr = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(enc_a, enc_b, 4'h0);
  endtask

  task automatic quad_move(input int n, input bit up);
    for (int i = 0; i < n; i++) begin
      ph = up ? (ph + 1) % 4 : (ph + 3) % 4;
      tick(gray[ph][0], gray[ph][1], 4'h0);
      idle(1);
    end
    idle(3);
  endtask

  task automatic b_toggle(input int n);
    for (int i = 0; i < n; i++) begin
      tick(enc_a, !enc_b, 4'h0);
      idle(1);
    end
    idle(3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [W-1:0] base;
    hist_a.push_back(3'b000);
    hist_b.push_back(3'b000);
    m_pos = 0; m_dir = 0; m_flags = 0; m_up = 0; m_dn = 0; m_ovf = 0; m_unf = 0;
    ph = 0;
    rst_n = 0; enc_a = 0; enc_b = 0; cnt_mode = 0; edge_sel = 2'b01; no_wrap = 0;
    max_pos = 5; cmp_pos = 16'hFFFF; flag_clr = 0; irq_en = 0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 pos", pos, 0);
    chk("R1 flags", flags, 0);
    chk("R1 dir_down", dir_down, 0);
    rst_n = 1;
    idle(4);

    // R2 R3: four forward steps, then check the latency pulse R13
    quad_move(4, 1);
    chk("R2 R3 forward position", pos, 4);
    chk("R9 up keeps dir", dir_down, 0);
    // R13: latency of one step
    ph = (ph + 1) % 4;
    tick(gray[ph][0], gray[ph][1], 4'h0);
    tick(enc_a, enc_b, 4'h0);
    chk("R13 no change after 2 edges", pos, 4);
    tick(enc_a, enc_b, 4'h0);
    chk("R13 counted on third edge", pos, 5);
    chk("R13 ev_up pulse", ev_up, 1);
    tick(enc_a, enc_b, 4'h0);
    chk("R13 ev_up one cycle", ev_up, 0);
    idle(2);
    // R6: overflow wraps to 0
    quad_move(1, 1);
    chk("R6 wrap to zero", pos, 0);
    chk("R6 overflow flag", flags[0], 1);
    // R7 R9: reverse, underflow reload
    quad_move(1, 0);
    chk("R7 reload max", pos, 5);
    chk("R7 underflow flag", flags[1], 1);
    chk("R9 dir down", dir_down, 1);
    chk("R9 inversion flag", flags[2], 1);
    idle(6);
    chk("R11 flags stay set", flags[1:0], 2'b11);
    tick(enc_a, enc_b, 4'hF);
    chk("R11 clear strobe", flags, 0);

    // R4: both phases flip together
    ph = (ph + 2) % 4;
    tick(gray[ph][0], gray[ph][1], 4'h0);
    idle(5);
    chk("R4 no count on double change", pos, 5);
    chk("R4 no event", flags, 0);

    // R8: no-wrap past maximum
    quad_move(5, 1);          // 5 -> 0 (wrap), then up to 4
    tick(enc_a, enc_b, 4'hF);
    no_wrap = 1;
    quad_move(2, 1);          // 4 -> 5 -> 6
    chk("R8 passes maximum", pos, 6);
    chk("R8 overflow flag", flags[0], 1);
    no_wrap = 0;
    quad_move(3, 0);
    chk("R8 back below max", pos, 3);

    // R10 R12: compare match and irq gating
    tick(enc_a, enc_b, 4'hF);
    cmp_pos = 5;
    quad_move(2, 1);
    chk("R10 match flag", flags[3], 1);
    irq_en = 4'b1000;
    #1 chk("R12 irq enabled", irq, 1);
    irq_en = 4'b0010;
    #1 chk("R12 irq masked", irq, 0);
    irq_en = 0;
    idle(1);

    // R5: step-and-direction mode
    cnt_mode = 1; edge_sel = 2'b01; max_pos = 100;
    tick(1'b1, enc_b, 4'h0);  // A change alone
    idle(4);
    base = pos;
    chk("R5 A edge ignored", pos, base);
    b_toggle(4);
    chk("R5 rising edges only", pos, base + 2);
    edge_sel = 2'b11;
    tick(1'b0, enc_b, 4'h0);
    idle(4);
    b_toggle(4);
    chk("R5 both edges down", pos, base - 2);
    edge_sel = 2'b10;
    tick(1'b1, enc_b, 4'h0);
    idle(4);
    b_toggle(4);
    chk("R5 falling edges up", pos, base);
    edge_sel = 2'b00;
    b_toggle(2);
    chk("R5 no edge selected", pos, base);

    // random mix compared every cycle against the model
    cnt_mode = 0; max_pos = 7; cmp_pos = 3; irq_en = 4'b1011;
    tick(gray[ph][0], gray[ph][1], 4'h0);
    idle(4);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4)       ph = (ph + 1) % 4;
      else if (r < 8)  ph = (ph + 3) % 4;
      else if (r == 8) ph = (ph + 2) % 4;
      if (i % 500 == 250) no_wrap = !no_wrap;
      tick(gray[ph][0], gray[ph][1], ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0);
      if (no_wrap && pos > 20) begin
        no_wrap = 0;
      end
    end
    idle(4);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule